// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing end of a small byte-addressed nonvolatile memory. It samples the two-wire bus (serial clock and serial data) with the system clock and recognises START and STOP conditions. It matches the slave byte against a fixed prefix and a set of pin-strapped device bits, and pulls the data line low through an open-drain enable to acknowledge or to send a zero. It keeps the internal byte pointer, which persists between transactions.

In a write transaction every received data byte is handed to a separate write-buffer block as an address/data pair. The address advances only inside the current page. A STOP after at least one data byte tells that block to start its internal write. A repeated START after data bytes tells it to discard them. While the buffer reports busy, the engine refuses to acknowledge its slave byte, so a host can poll for completion. Reads fetch bytes through a plain combinational read port. A read can take the current pointer or a pointer loaded by a preceding address-only write. It carries on through the whole array for as long as the host acknowledges, and wraps at the end of the array.

The array size is set by `MEM_AW`, which is 8 or 9. In the 9-bit variant, one device bit of the slave byte becomes pointer bit 8.

Top module: `i2c_mem_slave`

## Requirements
- R1: Bus activity is ignored until a START (data falling while clock is high). A START in any state begins a new slave byte, and a STOP (data rising while clock is high) returns the engine to idle.
- R2: The slave byte is acknowledged only when bits 7:4 equal 1010 and the device bits match `dev_sel_i`. With `MEM_AW`=8, bits 3:1 must equal `dev_sel_i[2:0]`. Bit 0 selects the direction (1 read, 0 write). On a mismatch the data line stays released until the next START.
- R3: With `MEM_AW`=9, bits 3:2 are compared with `dev_sel_i[2:1]`, and bit 1 is loaded into pointer bit 8.
- R4: The engine drives the data line low during the ninth clock after a matching slave byte, after the address byte and after every write data byte.
- R5: Each write data byte is pushed on `wb_push_o` with the current pointer. After each push, only the low `PAGE_W` pointer bits advance, so writes past the page end wrap to the page start.
- R6: A STOP after one or more data bytes pulses `wb_commit_o`. A START after data bytes pulses `wb_drop_o`. A transaction without data bytes pulses neither. The three strobes are never active together.
- R7: While `busy_i` is high, the slave byte is not acknowledged.
- R8: Read data goes out MSB first. The data line changes only while the clock is low. The line is released in the ninth clock, the next byte follows a host ACK, and a host NoACK ends the transfer.
- R9: A read without a preceding address byte starts at the pointer left by the last access, including an access in an earlier transaction.
- R10: An address-only write followed by a repeated START and a read slave byte reads from the loaded address.
- R11: During reads the pointer advances by one per byte over the whole array and wraps from the last location to 0.
- R12: After reset the data line is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| dev_sel_i | input | 3 | Strapped device select bits |
| busy_i | input | 1 | Write buffer busy with an internal write |
| wb_push_o | output | 1 | Data byte strobe to the write buffer |
| wb_addr_o | output | MEM_AW | Byte address for the pushed data |
| wb_data_o | output | 8 | Pushed data byte |
| wb_commit_o | output | 1 | Start internal write of pushed bytes |
| wb_drop_o | output | 1 | Discard pushed bytes |
| rd_addr_o | output | MEM_AW | Array read address (current pointer) |
| rd_data_i | input | 8 | Array read data, combinational |

## Verification
The assertions check on every cycle that the data enable never moves while the synchronized clock is high, and that it is off in idle. They also check that the three buffer strobes are exclusive, that a pushed byte leaves the page bits of the pointer untouched, that each transmitted byte steps the pointer by exactly one modulo the array, and that a busy buffer suppresses the slave-byte ACK. Only the bench's scenarios show the end-to-end behaviour: page wrap, commit and drop as seen in the array contents, pointer persistence across transactions, array-end wrap, device matching in both widths, and the polling sequence against a real busy window.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} state_e;
  typedef enum logic [1:0] {K_DEV, K_ADDR, K_DATA} kind_e;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_mem_bus_sync.sv
module i2c_mem_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  // idle bus is high: reset to 1 so no edge is seen at release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/i2c_mem_ptr.sv
module i2c_mem_ptr #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_hi_i,
  input  logic          hi_i,
  input  logic          set_lo_i,
  input  logic [7:0]    lo_i,
  input  logic          inc_page_i,
  input  logic          inc_all_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_d, hi_val;

  if (AW == 9) begin : g_a8
    assign hi_val = {hi_i, ptr_q[7:0]};
  end else begin : g_no_a8
    logic unused_hi;
    assign unused_hi = hi_i;
    assign hi_val    = ptr_q;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (set_hi_i)   ptr_d = hi_val;
    if (set_lo_i)   ptr_d[7:0] = lo_i;
    if (inc_page_i) ptr_d = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
    if (inc_all_i)  ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int unsigned MEM_AW = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        dev_sel_i,
  input  logic              busy_i,
  output logic              wb_push_o,
  output logic [MEM_AW-1:0] wb_addr_o,
  output logic [7:0]        wb_data_o,
  output logic              wb_commit_o,
  output logic              wb_drop_o,
  output logic [MEM_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_mem_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  state_e            state_q;
  kind_e             kind_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        rx_q, tx_q, wb_data_q;
  logic [MEM_AW-1:0] wb_addr_q, ptr;
  logic              rw_q, mack_q, pend_q, oe_q;
  logic              push_q, commit_q, drop_q;

  logic byte_done, sel_ok, dev_hit, rx_end;
  logic set_hi, set_lo, inc_page, inc_all;

  assign byte_done = scl_fall && (bitcnt_q == BYTE_BITS);

  if (MEM_AW == 9) begin : g_sel_wide
    logic unused_sel;
    assign unused_sel = dev_sel_i[0];
    assign sel_ok     = (rx_q[3:2] == dev_sel_i[2:1]);
  end else begin : g_sel_narrow
    assign sel_ok = (rx_q[3:1] == dev_sel_i);
  end

  assign dev_hit  = (rx_q[7:4] == DEV_PREFIX) && sel_ok && !busy_i;
  assign rx_end   = (state_q == ST_RX) && byte_done;
  assign set_hi   = rx_end && (kind_q == K_DEV) && dev_hit;
  assign set_lo   = rx_end && (kind_q == K_ADDR);
  assign inc_page = rx_end && (kind_q == K_DATA);
  assign inc_all  = (state_q == ST_TX) && byte_done;

  i2c_mem_ptr #(.AW(MEM_AW), .PW(PAGE_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_hi_i   (set_hi),
    .hi_i       (rx_q[1]),
    .set_lo_i   (set_lo),
    .lo_i       (rx_q),
    .inc_page_i (inc_page),
    .inc_all_i  (inc_all),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_DEV;
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      wb_data_q <= '0;
      wb_addr_q <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      pend_q    <= 1'b0;
      oe_q      <= 1'b0;
      push_q    <= 1'b0;
      commit_q  <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      push_q   <= 1'b0;
      commit_q <= 1'b0;
      drop_q   <= 1'b0;
      if (bus_start) begin
        state_q  <= ST_RX;
        kind_q   <= K_DEV;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
        drop_q   <= pend_q;
        pend_q   <= 1'b0;
      end else if (bus_stop) begin
        state_q  <= ST_IDLE;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise) begin
              rx_q     <= {rx_q[6:0], sda_s};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
              unique case (kind_q)
                K_DEV: begin
                  if (dev_hit) begin
                    oe_q    <= 1'b1;
                    rw_q    <= rx_q[0];
                    state_q <= ST_RX_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_ADDR: begin
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                default: begin
                  oe_q      <= 1'b1;
                  push_q    <= 1'b1;
                  wb_addr_q <= ptr;
                  wb_data_q <= rx_q;
                  pend_q    <= 1'b1;
                  state_q   <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (kind_q == K_DEV && rw_q) begin
                state_q <= ST_TX;
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                kind_q  <= (kind_q == K_DEV) ? K_ADDR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
              oe_q    <= 1'b0;
              state_q <= ST_TX_ACK;
            end else if (scl_fall) begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q  <= ST_TX;
                tx_q     <= rd_data_i;
                oe_q     <= ~rd_data_i[7];
                bitcnt_q <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign wb_push_o   = push_q;
  assign wb_addr_o   = wb_addr_q;
  assign wb_data_o   = wb_data_q;
  assign wb_commit_o = commit_q;
  assign wb_drop_o   = drop_q;
  assign rd_addr_o   = ptr;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
#(
  parameter int unsigned MEM_AW = 8,
  parameter int unsigned PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              busy_i,
  input state_e            state_q,
  input kind_e             kind_q,
  input logic              byte_done,
  input logic              wb_push_o,
  input logic              wb_commit_o,
  input logic              wb_drop_o,
  input logic [MEM_AW-1:0] wb_addr_o,
  input logic [MEM_AW-1:0] rd_addr_o
);
  // R8
  oe_quiet_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  // R2
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_push_o, wb_commit_o, wb_drop_o}));

  // R7
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX && kind_q == K_DEV && byte_done && busy_i) |=> !sda_oe_o);

  // R5
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_push_o |-> (rd_addr_o[MEM_AW-1:PAGE_W] == wb_addr_o[MEM_AW-1:PAGE_W]));

  // R11
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_ACK && $past(state_q) == ST_TX) |->
      (rd_addr_o == $past(rd_addr_o) + MEM_AW'(1)));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .busy_i      (busy_i),
  .state_q     (state_q),
  .kind_q      (kind_q),
  .byte_done   (byte_done),
  .wb_push_o   (wb_push_o),
  .wb_commit_o (wb_commit_o),
  .wb_drop_o   (wb_drop_o),
  .wb_addr_o   (wb_addr_o),
  .rd_addr_o   (rd_addr_o)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int BUSY_CYC   = 600;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       oe8, oe9;
  wire        sda_bus = m_sda & ~oe8 & ~oe9;

  logic       push8, commit8, drop8, push9, commit9, drop9;
  logic [7:0] waddr8, raddr8, wdata8, wdata9;
  logic [8:0] waddr9, raddr9;
  logic [7:0] mem8 [256];
  logic [7:0] mem9 [512];
  logic [7:0] exp8 [256];
  logic [7:0] exp9 [512];
  int         busy_cnt;
  logic       busy8;
  assign busy8 = (busy_cnt != 0);

  i2c_mem_slave #(.MEM_AW(8), .PAGE_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(oe8),
    .dev_sel_i(3'b010), .busy_i(busy8),
    .wb_push_o(push8), .wb_addr_o(waddr8), .wb_data_o(wdata8),
    .wb_commit_o(commit8), .wb_drop_o(drop8),
    .rd_addr_o(raddr8), .rd_data_i(mem8[raddr8])
  );

  i2c_mem_slave #(.MEM_AW(9), .PAGE_W(4)) dut9 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(oe9),
    .dev_sel_i(3'b110), .busy_i(1'b0),
    .wb_push_o(push9), .wb_addr_o(waddr9), .wb_data_o(wdata9),
    .wb_commit_o(commit9), .wb_drop_o(drop9),
    .rd_addr_o(raddr9), .rd_data_i(mem9[raddr9])
  );

  int nchk = 0;
  int nerr = 0;
  int n_commit = 0;
  int n_drop = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // write buffer model: collect, apply on commit, busy window after
  logic [8:0] q_a[$];
  logic [7:0] q_d[$];
  logic [8:0] q9_a[$];
  logic [7:0] q9_d[$];
  always @(posedge clk) begin
    if (push8) begin q_a.push_back({1'b0, waddr8}); q_d.push_back(wdata8); end
    if (drop8) begin q_a.delete(); q_d.delete(); n_drop++; end
    if (commit8) begin
      foreach (q_a[k]) mem8[q_a[k][7:0]] <= q_d[k];
      q_a.delete(); q_d.delete();
      busy_cnt <= BUSY_CYC;
      n_commit++;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (push9) begin q9_a.push_back(waddr9); q9_d.push_back(wdata9); end
    if (drop9) begin q9_a.delete(); q9_d.delete(); end
    if (commit9) begin
      foreach (q9_a[k]) mem9[q9_a[k]] <= q9_d[k];
      q9_a.delete(); q9_d.delete();
    end
  end

  // per-clock: enable must not move while the bus clock is high (R8)
  logic prev_scl = 1'b1;
  logic prev_oe8 = 1'b0;
  logic prev_oe9 = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && m_scl && prev_scl) begin
      chk(oe8 == prev_oe8, "R8 dut enable moved with clock high", oe8, prev_oe8);
      chk(oe9 == prev_oe9, "R8 dut9 enable moved with clock high", oe9, prev_oe9);
    end
    prev_scl = m_scl;
    prev_oe8 = oe8;
    prev_oe9 = oe9;
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q(); m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q(); m_sda = 1'b1; wait_q(); wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q(); m_scl = 1'b1; wait_q(); wait_q(); m_scl = 1'b0; wait_q();
    end
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    acked = !sda_bus;
    wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); m_scl = 1'b1; wait_q(); b[i] = sda_bus; wait_q(); m_scl = 1'b0;
    end
    wait_q(); m_sda = mack ? 1'b0 : 1'b1; wait_q(); m_scl = 1'b1; wait_q(); wait_q();
    m_scl = 1'b0; wait_q(); m_sda = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy8) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] expv(input bit nine, input int a);
    return nine ? exp9[a % 512] : exp8[a % 256];
  endfunction

  logic [7:0] wbuf [16];

  task automatic write_page(input logic [7:0] devw, input int addr, input int n,
                            input bit nine, input string tag);
    bit ack;
    int base;
    bus_start();
    send_byte(devw, ack);             chk(ack, {tag, " R4 slave byte ack"}, ack, 1);
    send_byte(addr[7:0], ack);        chk(ack, {tag, " R4 address ack"}, ack, 1);
    base = addr & ~15;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);        chk(ack, {tag, " R4 data ack"}, ack, 1);
      if (nine) exp9[base + ((addr + k) & 15)] = wbuf[k];
      else      exp8[base + ((addr + k) & 15)] = wbuf[k];
    end
    bus_stop();
    wait_idle();
  endtask

  task automatic rand_read(input logic [7:0] devw, input int addr, input int n,
                           input bit nine, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(devw, ack);             chk(ack, {tag, " R10 slave byte ack"}, ack, 1);
    send_byte(addr[7:0], ack);        chk(ack, {tag, " R10 address ack"}, ack, 1);
    bus_start();
    send_byte(devw | 8'h01, ack);     chk(ack, {tag, " R10 read slave byte ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == expv(nine, addr + k), tag, b, expv(nine, addr + k));
    end
    bus_stop();
  endtask

  task automatic cur_read(input logic [7:0] devr, input int addr, input int n,
                          input bit nine, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(devr, ack);             chk(ack, {tag, " slave byte ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == expv(nine, addr + k), tag, b, expv(nine, addr + k));
    end
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit ack;
    int c0, d0;
    logic [7:0] b;
    busy_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      mem8[i] = 8'(i) ^ 8'h5A;
      exp8[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 512; i++) begin
      mem9[i] = 8'(i * 7 + 1);
      exp9[i] = 8'(i * 7 + 1);
    end
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(!oe8 && !oe9, "R12 data line released in reset", {oe8, oe9}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!push8 && !commit8 && !drop8 && !oe8, "R12 quiet after reset",
        {push8, commit8, drop8, oe8}, 0);

    // R1: no START, a matching slave byte is ignored
    m_scl = 1'b0; wait_q();
    send_byte(8'hA4, ack);
    chk(!ack, "R1 slave byte without START", ack, 0);
    bus_stop();

    // byte write then busy polling
    wbuf[0] = 8'h3C;
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R4 byte write slave ack", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R4 byte write address ack", ack, 1);
    send_byte(8'h3C, ack); chk(ack, "R4 byte write data ack", ack, 1);
    exp8[16'h10] = 8'h3C;
    c0 = n_commit;
    bus_stop();
    repeat (4) @(negedge clk);
    chk(n_commit == c0 + 1, "R6 commit on STOP after data", n_commit, c0 + 1);
    bus_start();
    send_byte(8'hA4, ack);
    chk(!ack, "R7 no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    c0 = n_commit;
    bus_start();
    send_byte(8'hA4, ack);
    chk(ack, "R7 ack once idle", ack, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(n_commit == c0, "R6 no commit without data", n_commit, c0);

    // R10 random read, R9 pointer persists into next transaction
    rand_read(8'hA4, 8'h10, 1, 1'b0, "R10 random read");
    cur_read(8'hA5, 8'h11, 1, 1'b0, "R9 current address read");
    cur_read(8'hA5, 8'h12, 2, 1'b0, "R9 pointer kept across reads");

    // R5 page wrap: start near page end
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    write_page(8'hA4, 8'h2E, 4, 1'b0, "R5 page write");
    rand_read(8'hA4, 8'h20, 16, 1'b0, "R5 R8 page wrap readback");

    // R11 sequential read wraps at end of array
    rand_read(8'hA4, 8'hFE, 4, 1'b0, "R11 array end wrap");
    cur_read(8'hA5, 8'h02, 1, 1'b0, "R9 R11 pointer after wrap");

    // R2 mismatches
    bus_start();
    send_byte(8'hA6, ack); chk(!ack, "R2 wrong device bits", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored until next START", ack, 0);
    bus_start();
    send_byte(8'hB4, ack); chk(!ack, "R2 wrong prefix", ack, 0);
    bus_stop();

    // R6 repeated START after data drops the bytes
    d0 = n_drop; c0 = n_commit;
    bus_start();
    send_byte(8'hA4, ack); chk(ack, "R6 drop slave ack", ack, 1);
    send_byte(8'h40, ack); chk(ack, "R6 drop address ack", ack, 1);
    send_byte(8'h99, ack); chk(ack, "R6 drop data ack", ack, 1);
    bus_start();
    send_byte(8'hA5, ack); chk(ack, "R6 read after drop ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == exp8[8'h41], "R6 R9 read after dropped byte", b, exp8[8'h41]);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(n_drop == d0 + 1, "R6 drop strobe", n_drop, d0 + 1);
    chk(n_commit == c0, "R6 no commit after drop", n_commit, c0);
    rand_read(8'hA4, 8'h40, 1, 1'b0, "R6 dropped byte not written");

    // R3 9-bit variant: bit 1 is pointer bit 8
    wbuf[0] = 8'h77; wbuf[1] = 8'h78;
    write_page(8'hAE, 9'h105, 2, 1'b1, "R3 high half write");
    rand_read(8'hAE, 9'h105, 2, 1'b1, "R3 high half read");
    rand_read(8'hAC, 9'h005, 2, 1'b1, "R3 low half untouched");
    rand_read(8'hAE, 9'h1FF, 2, 1'b1, "R3 R11 wide array wrap");
    bus_start();
    send_byte(8'hAA, ack); chk(!ack, "R3 device bits 3:2 compared", ack, 0);
    bus_stop();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule